// File: doc/BRIEF.md
# Split-Width Buffer Copy Sequencer

This block moves a buffer between a byte-wide valid/ready stream and a shared memory that is 16 bits wide. The buffer may start at any byte offset and hold any number of bytes. The memory takes 16-bit accesses only at even offsets, and 8-bit accesses at any offset. A single start strobe supplies the direction, the start offset and the byte count. The sequencer then works through the buffer on its own. It handles the unaligned front, the aligned middle and the leftover end, and each memory access waits for its acknowledge.

A copy out of memory is preceded by a read-ordering fence request for the whole range, so that earlier writes from other agents are visible before the first fetch. A copy into memory is followed by a write-ordering fence request for the same range, so that the data has landed before completion is signalled. Completion is a one-cycle `done` pulse. `busy` stays high from the accepted start until that pulse.

Top module: `copy_seq`

## Requirements
- R1: When the start offset is odd and the count is non-zero, the first memory access is an 8-bit access (`mem_wide`=0) at the start offset.
- R2: After any head byte, floor(remaining/2) consecutive 16-bit accesses (`mem_wide`=1) are issued at increasing even offsets, each 2 above the previous one.
- R3: When the count left after the head byte is odd, the last access is an 8-bit access at offset start+count-1.
- R4: In a 16-bit access, bits 7:0 of `mem_wdata`/`mem_rdata` carry the byte at the lower (even) offset and bits 15:8 carry the next byte. An 8-bit access carries its byte on bits 7:0.
- R5: A copy from memory (`to_mem`=0) raises exactly one fence request with `fence_to_mem`=0, `fence_off`=start offset and `fence_len`=count. It is acknowledged before the first memory access.
- R6: A copy into memory (`to_mem`=1) raises exactly one fence request with `fence_to_mem`=1 and the original offset and count. It is raised only after the last memory access is acknowledged, and `done` follows the fence acknowledge.
- R7: A count of zero gives `done` in the cycle after the start is accepted, with no memory access and no fence.
- R8: A memory request holds its address, width and direction stable until `mem_ack` is seen.
- R9: Stream bytes move only on valid&&ready. They are taken or delivered in increasing address order, and the stream may stall for any number of cycles between accesses.
- R10: After reset the block is idle: `busy`, `done`, `mem_req`, `fence_req`, `in_ready` and `out_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted when idle |
| to_mem | input | 1 | 1: stream into memory, 0: memory out to stream |
| start_off | input | AW | Byte offset of the buffer |
| byte_cnt | input | CW | Buffer length in bytes |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| fence_req | output | 1 | Ordering fence request |
| fence_to_mem | output | 1 | Fence kind: 1 write-ordering, 0 read-ordering |
| fence_off | output | AW | Fence range start |
| fence_len | output | CW | Fence range length |
| fence_ack | input | 1 | Fence completed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | 16-bit access (else 8-bit) |
| mem_addr | output | AW | Byte offset of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Sequencer takes a byte |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | 8 | Outbound byte |
| out_ready | input | 1 | Sink takes the byte |

## Verification
On every cycle, assertions check four things: the parity rule for wide accesses, the holding of a pending request until its acknowledge, that fence and memory requests never overlap, and where the fence falls relative to the bytes still outstanding for each direction. They also check the one-cycle completion of an empty copy. Only the bench scenarios can show the exact sequence of head, body and tail accesses for a given offset and length. The same holds for the byte lane order seen in memory, the ordering of delivered stream bytes, and the memory left untouched beside the buffer. Those scenarios run under a throttled acknowledge and a stalling stream.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FPRE   = 3'd1,
    ST_GATHER = 3'd2,
    ST_ACCESS = 3'd3,
    ST_EMIT   = 3'd4,
    ST_FPOST  = 3'd5,
    ST_FINISH = 3'd6
  } seq_state_t;
endpackage

// File: rtl/cps_planner.sv
module cps_planner #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] cur_off,
  input  logic [CW-1:0] remain,
  output logic          wide,
  output logic [1:0]    step
);
  localparam logic [CW-1:0] TWO = CW'(2);

  always_comb begin
    wide = (cur_off[0] == 1'b0) && (remain >= TWO);
    step = wide ? 2'd2 : 2'd1;
  end
endmodule

// File: rtl/cps_cursor.sv
module cps_cursor #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_off,
  input  logic [CW-1:0] load_cnt,
  input  logic          adv,
  input  logic [1:0]    step,
  output logic [AW-1:0] cur_off,
  output logic [CW-1:0] remain,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_off <= '0;
      remain  <= '0;
    end else if (load) begin
      cur_off <= load_off;
      remain  <= load_cnt;
    end else if (adv) begin
      cur_off <= cur_off + AW'(step);
      remain  <= remain - CW'(step);
    end
  end

  assign last = (remain == CW'(step));
endmodule

// File: rtl/cps_lanebuf.sv
module cps_lanebuf #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 put_en,
  input  logic [$clog2(LANES)-1:0] put_lane,
  input  logic [7:0]           put_byte,
  input  logic                 word_en,
  input  logic [LANES*8-1:0]   word_in,
  input  logic [$clog2(LANES)-1:0] get_lane,
  output logic [LANES*8-1:0]   word_q,
  output logic [7:0]           get_byte
);
  logic [7:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_q[g] <= '0;
      else if (word_en) lane_q[g] <= word_in[g*8 +: 8];
      else if (put_en && (put_lane == g)) lane_q[g] <= put_byte;
    end
    assign word_q[g*8 +: 8] = lane_q[g];
  end

  assign get_byte = lane_q[get_lane];
endmodule

// File: rtl/copy_seq.sv
module copy_seq
  import cps_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          to_mem,
  input  logic [AW-1:0] start_off,
  input  logic [CW-1:0] byte_cnt,
  output logic          busy,
  output logic          done,
  output logic          fence_req,
  output logic          fence_to_mem,
  output logic [AW-1:0] fence_off,
  output logic [CW-1:0] fence_len,
  input  logic          fence_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready
);
  seq_state_t state_q, state_d;
  logic          dir_q;
  logic [AW-1:0] orig_off_q;
  logic [CW-1:0] orig_len_q;
  logic          idx_q, idx_d;

  logic          accept, cur_load, cur_adv, last_acc, wide;
  logic [1:0]    step;
  logic [AW-1:0] cur_off;
  logic [CW-1:0] remain;
  logic          byte_last;
  logic          put_en, word_en;
  logic [15:0]   word_q;
  logic [7:0]    get_byte;

  assign accept   = (state_q == ST_IDLE) && start;
  assign cur_load = accept;

  cps_cursor #(.AW(AW), .CW(CW)) u_cur (
    .clk(clk), .rst(rst), .load(cur_load), .load_off(start_off),
    .load_cnt(byte_cnt), .adv(cur_adv), .step(step),
    .cur_off(cur_off), .remain(remain), .last(last_acc)
  );

  cps_planner #(.AW(AW), .CW(CW)) u_plan (
    .cur_off(cur_off), .remain(remain), .wide(wide), .step(step)
  );

  cps_lanebuf #(.LANES(2)) u_buf (
    .clk(clk), .rst(rst), .put_en(put_en), .put_lane(idx_q),
    .put_byte(in_data), .word_en(word_en), .word_in(mem_rdata),
    .get_lane(idx_q), .word_q(word_q), .get_byte(get_byte)
  );

  // last byte of the current access: lane 1 for a word, lane 0 for a byte
  assign byte_last = wide ? idx_q : 1'b1;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cur_adv = 1'b0;
    put_en  = 1'b0;
    word_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        idx_d = 1'b0;
        if (start) begin
          if (byte_cnt == '0) state_d = ST_FINISH;
          else if (to_mem)    state_d = ST_GATHER;
          else                state_d = ST_FPRE;
        end
      end
      ST_FPRE: if (fence_ack) state_d = ST_ACCESS;
      ST_GATHER: begin
        if (in_valid) begin
          put_en = 1'b1;
          if (byte_last) begin
            idx_d   = 1'b0;
            state_d = ST_ACCESS;
          end else begin
            idx_d = 1'b1;
          end
        end
      end
      ST_ACCESS: begin
        if (mem_ack) begin
          if (dir_q) begin
            cur_adv = 1'b1;
            state_d = last_acc ? ST_FPOST : ST_GATHER;
          end else begin
            word_en = 1'b1;
            idx_d   = 1'b0;
            state_d = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (byte_last) begin
            cur_adv = 1'b1;
            idx_d   = 1'b0;
            state_d = last_acc ? ST_FINISH : ST_ACCESS;
          end else begin
            idx_d = 1'b1;
          end
        end
      end
      ST_FPOST:  if (fence_ack) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= 1'b0;
      dir_q      <= 1'b0;
      orig_off_q <= '0;
      orig_len_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (accept) begin
        dir_q      <= to_mem;
        orig_off_q <= start_off;
        orig_len_q <= byte_cnt;
      end
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_FINISH);
  assign fence_req    = (state_q == ST_FPRE) || (state_q == ST_FPOST);
  assign fence_to_mem = dir_q;
  assign fence_off    = orig_off_q;
  assign fence_len    = orig_len_q;
  assign mem_req      = (state_q == ST_ACCESS);
  assign mem_we       = dir_q;
  assign mem_wide     = wide;
  assign mem_addr     = cur_off;
  assign mem_wdata    = word_q;
  assign in_ready     = (state_q == ST_GATHER);
  assign out_valid    = (state_q == ST_EMIT);
  assign out_data     = get_byte;

  // ---------------- assertions ----------------
  assert_wide_even_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_wide) |-> (mem_addr[0] == 1'b0));

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wide) && $stable(mem_we)));

  assert_rd_fence_first_R5: assert property (@(posedge clk) disable iff (rst)
    (fence_req && !fence_to_mem) |-> (remain == fence_len));

  assert_wr_fence_last_R6: assert property (@(posedge clk) disable iff (rst)
    (fence_req && fence_to_mem) |-> (remain == '0));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(fence_req && mem_req));

  assert_empty_done_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && byte_cnt == '0) |=> (done && !mem_req && !fence_req));

  assert_one_dir_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_copy_seq.sv
module sim_copy_seq;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          start = 0, to_mem = 0;
  logic [AW-1:0] start_off = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic          busy, done, fence_req, fence_to_mem, fence_ack = 0;
  logic [AW-1:0] fence_off, mem_addr;
  logic [CW-1:0] fence_len;
  logic          mem_req, mem_we, mem_wide, mem_ack = 0;
  logic [15:0]   mem_wdata, mem_rdata = '0;
  logic          in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0]    in_data = '0, out_data;

  copy_seq #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .to_mem(to_mem), .start_off(start_off),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .fence_req(fence_req),
    .fence_to_mem(fence_to_mem), .fence_off(fence_off), .fence_len(fence_len),
    .fence_ack(fence_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mem [256];
  int exp_acc[$];     // addr*2 + wide
  logic [7:0] src[$];
  int fence_cnt = 0, rd_ptr = 0, cur_off_i = 0, cur_cnt_i = 0;
  logic cur_dir = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory, fence and stream responders, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && (cyc % 3 != 0)) begin
        int a;
        a = int'(mem_addr);
        chk(exp_acc.size() > 0, "R1/R2/R3 unexpected access", a, -1);
        if (exp_acc.size() > 0) begin
          int e;
          e = exp_acc.pop_front();
          chk((a * 2 + int'(mem_wide)) == e, "R1/R2/R3 access addr*2+wide", a * 2 + int'(mem_wide), e);
        end
        chk(mem_we == cur_dir, "R6 access direction", int'(mem_we), int'(cur_dir));
        chk(fence_cnt == (cur_dir ? 0 : 1), "R5/R6 fence position vs access", fence_cnt, cur_dir ? 0 : 1);
        if (mem_we) begin
          mem[a[7:0]] = mem_wdata[7:0];
          if (mem_wide) mem[a[7:0] + 8'd1] = mem_wdata[15:8];
        end else begin
          mem_rdata = mem_wide ? {mem[a[7:0] + 8'd1], mem[a[7:0]]} : {8'hEE, mem[a[7:0]]};
        end
        mem_ack = 1'b1;
      end
      if (fence_ack) fence_ack = 1'b0;
      else if (fence_req && (cyc % 2 == 0)) begin
        fence_cnt++;
        chk(fence_to_mem == cur_dir, "R5/R6 fence kind", int'(fence_to_mem), int'(cur_dir));
        chk(int'(fence_off) == cur_off_i, "R5/R6 fence offset", int'(fence_off), cur_off_i);
        chk(int'(fence_len) == cur_cnt_i, "R5/R6 fence length", int'(fence_len), cur_cnt_i);
        if (cur_dir) chk(exp_acc.size() == 0, "R6 fence after last access", exp_acc.size(), 0);
        fence_ack = 1'b1;
      end
      out_ready = (cyc % 4 != 1);
      if (out_valid && out_ready) begin
        chk(out_data == mem[8'(rd_ptr)], "R4/R9 read byte order", int'(out_data), int'(mem[8'(rd_ptr)]));
        rd_ptr++;
      end
      if (src.size() > 0 && (cyc % 5 != 2)) begin
        in_valid = 1'b1;
        in_data  = src[0];
        if (in_ready) void'(src.pop_front());
      end else begin
        in_valid = 1'b0;
      end
    end
  end

  task automatic run(input bit dir, input int off, input int cnt);
    logic [7:0] orig[$];
    int o, r;
    cur_dir = dir; cur_off_i = off; cur_cnt_i = cnt; fence_cnt = 0; rd_ptr = off;
    exp_acc.delete();
    o = off; r = cnt;
    if (r > 0 && (o % 2) == 1) begin exp_acc.push_back(o * 2); o++; r--; end
    while (r >= 2) begin exp_acc.push_back(o * 2 + 1); o += 2; r -= 2; end
    if (r == 1) exp_acc.push_back(o * 2);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    if (dir) for (int i = 0; i < cnt; i++) begin
      src.push_back(8'(i * 13 + cnt));
      orig.push_back(8'(i * 13 + cnt));
    end
    @(negedge clk);
    start = 1; to_mem = dir; start_off = AW'(off); byte_cnt = CW'(cnt);
    @(negedge clk);
    start = 0;
    if (cnt == 0) chk(done == 1'b1, "R7 done one cycle after empty start", int'(done), 1);
    while (!done) @(negedge clk);
    chk(exp_acc.size() == 0, "R1/R2/R3 all accesses issued", exp_acc.size(), 0);
    chk(fence_cnt == (cnt != 0 ? 1 : 0), dir ? "R6 fence count" : "R5 fence count", fence_cnt, cnt != 0 ? 1 : 0);
    if (dir) begin
      for (int i = 0; i < cnt; i++)
        chk(mem[8'(off + i)] == orig[i], "R4 written byte lane", int'(mem[8'(off + i)]), int'(orig[i]));
      if (off > 0)
        chk(mem[8'(off - 1)] == (8'(off - 1) ^ 8'hA5), "R3 byte before untouched", int'(mem[8'(off - 1)]), int'(8'(off - 1) ^ 8'hA5));
      chk(mem[8'(off + cnt)] == (8'(off + cnt) ^ 8'hA5), "R3 byte after untouched", int'(mem[8'(off + cnt)]), int'(8'(off + cnt) ^ 8'hA5));
    end else begin
      chk(rd_ptr == off + cnt, "R9 read byte count", rd_ptr - off, cnt);
    end
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !fence_req && !in_ready && !out_valid,
        "R10 reset state", int'({busy, done, mem_req, fence_req, in_ready, out_valid}), 0);
    rst = 0;
    run(0, 3, 7);
    run(0, 4, 6);
    run(0, 5, 1);
    run(0, 2, 1);
    run(0, 10, 40);
    run(1, 3, 7);
    run(1, 8, 9);
    run(1, 1, 2);
    run(1, 6, 2);
    run(0, 7, 0);
    run(1, 9, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule